// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block stores incoming network packets in a circular region of packet memory built from 256-byte pages. Software names the first page of the region and the page just past its end. The block keeps a current-page pointer for the next arriving packet. Software keeps a boundary pointer that marks the oldest page it has not yet consumed. Each stored packet starts on a fresh page. Its body begins at offset 4 of that page, and once the body is complete the block fills offsets 0 to 3 with a small header: a status byte, the page where the following packet will begin, and a 16-bit length.

Bytes arrive as a stream framed by a start pulse and an end pulse. The end pulse carries the CRC and alignment error indications. The block never writes into the boundary page. When a packet would need that page, the block stops storing it, drops it and raises sticky overwrite, reset and missed flags. Errored packets are dropped unless a save option is set. A monitor option checks packets without storing any of them. Missed packets are tallied in an 8-bit counter whose top bit raises a flag.

Top module: `rrb_ring_mgr`

## Requirements
- R1: After reset every register reads 0 and `mem_we` is low.
- R2: Body byte i of a packet starting on page P is written to address {P, 4+i}. After offset 255 the write moves to offset 0 of the following page.
- R3: The page following the last ring page (the stop register minus one) is the first ring page.
- R4: For a stored packet the header goes to offsets 0..3 of its first page. The bytes, in offset order, are: status {5'b0, alignment error, CRC error, no error}, next-page pointer, length+4 low byte, length+4 high byte. All four are written after the body.
- R5: After the header is written, the current page equals the page after the last page the body used, with wrap applied.
- R6: A packet ending with a CRC or alignment error gets no header and leaves the current page unchanged. This holds while the save-errors bit (config bit 0) is clear. With that bit set, the packet is stored like a good one.
- R7: With the monitor bit (config bit 1) set, nothing is written to memory, the missed flag (status bit 2) is set and the tally counts up.
- R8: A packet that would enter the boundary page, or that starts while the current page equals the boundary, stops being written. It gets no header, the current page stays put, and status bits 0 (overwrite), 1 (reset) and 2 (missed) are set.
- R9: The reset flag (status bit 1) is cleared only by writing the boundary register with a value different from its present one. Writing status bit 1 has no effect.
- R10: Writing 1 to status bits 0, 2 or 3 clears that bit; writing 0 leaves it.
- R11: The tally (address 6) counts missed packets, and any write to it clears it. The counter-overflow flag (status bit 3) is set by the increment from 0x7F to 0x80.
- R12: Register addresses are: 0 first page, 1 stop page, 2 boundary, 3 current page, 4 config, 5 status, 6 tally. Addresses 0 to 4 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | One-cycle pulse opening a packet |
| rx_valid | input | 1 | A body byte is present on rx_data |
| rx_data | input | 8 | Body byte |
| rx_end | input | 1 | One-cycle pulse closing a packet, carries no byte |
| rx_crc_err | input | 1 | CRC error, sampled with rx_end |
| rx_fae_err | input | 1 | Alignment error, sampled with rx_end |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Write address {page, offset} |
| mem_wdata | output | 8 | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |

## Verification
A byte sampled at a clock edge appears on the memory port one cycle later. The four header writes follow the clock edge that sees `rx_end`, on the first to fourth cycles after it. The current page moves with the last header byte, and the flags and tally settle one cycle after the event that set them. The bench observes memory on falling edges, so each write is seen in the cycle it is due. It waits several idle cycles after every end pulse before reading registers, because register reads are combinational. On every clock it also checks that a write address lies inside the ring and outside the boundary page.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
    localparam int PG_W   = 8;
    localparam int OFF_W  = 8;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 16;
    localparam int RA_W   = 3;
    localparam int ADDR_W = PG_W + OFF_W;
    localparam logic [OFF_W-1:0] HDR_BYTES = OFF_W'(4);

    typedef logic [PG_W-1:0] page_t;

    typedef enum logic [RA_W-1:0] {
        RA_FIRST = 3'd0,
        RA_STOP  = 3'd1,
        RA_BNDRY = 3'd2,
        RA_CURR  = 3'd3,
        RA_CFG   = 3'd4,
        RA_STAT  = 3'd5,
        RA_TALLY = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    localparam int ST_OVW  = 0;
    localparam int ST_RST  = 1;
    localparam int ST_MISS = 2;
    localparam int ST_CNT  = 3;

    function automatic page_t pg_next(page_t p, page_t first, page_t stop);
        page_t inc;
        inc = p + 1'b1;
        return (inc == stop) ? first : inc;
    endfunction
endpackage

// File: rtl/rrb_tally.sv
module rrb_tally #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] value,
    output logic         msb_evt
);
    localparam logic [W-1:0] BELOW_MSB = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } tl_t;

    tl_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
        end else if (inc) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign value   = q.cnt;
    assign msb_evt = inc && !clr && (q.cnt == BELOW_MSB);
endmodule

// File: rtl/rrb_rx_engine.sv
module rrb_rx_engine
    import rrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_err,
    input  logic              rx_fae_err,
    input  logic              cfg_save,
    input  logic              cfg_mon,
    input  page_t             pg_first,
    input  page_t             pg_stop,
    input  page_t             pg_bndry,
    input  page_t             pg_curr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              commit_vld,
    output page_t             commit_pg,
    output logic              ovw_evt,
    output logic              miss_evt
);
    typedef enum logic [1:0] {S_IDLE, S_RECV, S_HDR} state_e;

    typedef struct packed {
        state_e             st;
        page_t              start_pg;
        page_t              wr_pg;
        logic [OFF_W-1:0]   wr_off;
        logic [LEN_W-1:0]   len;
        logic               skip;
        logic               miss;
        logic [1:0]         hdr_idx;
        logic [BYTE_W-1:0]  hdr_stat;
        page_t              hdr_next;
        logic               we;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  wdata;
        logic               commit;
        logic               ovw;
        logic               miss_ev;
    } eng_t;

    eng_t q, d;
    logic bad;

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.commit  = 1'b0;
        d.ovw     = 1'b0;
        d.miss_ev = 1'b0;
        bad       = rx_crc_err || rx_fae_err;
        case (q.st)
            S_IDLE: begin
                if (rx_start) begin
                    d.st       = S_RECV;
                    d.start_pg = pg_curr;
                    d.wr_pg    = pg_curr;
                    d.wr_off   = HDR_BYTES;
                    d.len      = LEN_W'(HDR_BYTES);
                    d.skip     = 1'b0;
                    d.miss     = 1'b0;
                    if (cfg_mon) begin
                        d.skip = 1'b1;
                        d.miss = 1'b1;
                    end else if (pg_curr == pg_bndry) begin
                        d.skip = 1'b1;
                        d.miss = 1'b1;
                        d.ovw  = 1'b1;
                    end
                end
            end
            S_RECV: begin
                if (rx_valid && !q.skip) begin
                    if (q.wr_off == '0 && q.wr_pg == pg_bndry) begin
                        d.skip = 1'b1;
                        d.miss = 1'b1;
                        d.ovw  = 1'b1;
                    end else begin
                        d.we     = 1'b1;
                        d.addr   = {q.wr_pg, q.wr_off};
                        d.wdata  = rx_data;
                        d.wr_off = q.wr_off + 1'b1;
                        d.len    = q.len + 1'b1;
                        if (q.wr_off == '1) begin
                            d.wr_pg = pg_next(q.wr_pg, pg_first, pg_stop);
                        end
                    end
                end
                if (rx_end) begin
                    d.st = S_IDLE;
                    if (q.skip) begin
                        d.miss_ev = q.miss;
                    end else if (!bad || cfg_save) begin
                        d.st       = S_HDR;
                        d.hdr_idx  = 2'd0;
                        d.hdr_stat = {5'b0, rx_fae_err, rx_crc_err, !bad};
                        d.hdr_next = (q.wr_off == '0) ? q.wr_pg
                                                      : pg_next(q.wr_pg, pg_first, pg_stop);
                    end
                end
            end
            S_HDR: begin
                d.we      = 1'b1;
                d.addr    = {q.start_pg, {(OFF_W-2){1'b0}}, q.hdr_idx};
                case (q.hdr_idx)
                    2'd0:    d.wdata = q.hdr_stat;
                    2'd1:    d.wdata = q.hdr_next;
                    2'd2:    d.wdata = q.len[BYTE_W-1:0];
                    default: d.wdata = q.len[LEN_W-1:BYTE_W];
                endcase
                d.hdr_idx = q.hdr_idx + 1'b1;
                if (q.hdr_idx == 2'd3) begin
                    d.commit = 1'b1;
                    d.st     = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we     = q.we;
    assign mem_addr   = q.addr;
    assign mem_wdata  = q.wdata;
    assign commit_vld = q.commit;
    assign commit_pg  = q.hdr_next;
    assign ovw_evt    = q.ovw;
    assign miss_evt   = q.miss_ev;
endmodule

// File: rtl/rrb_regs.sv
module rrb_regs
    import rrb_pkg::*;
#(
    parameter int TALLY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    input  logic               commit_vld,
    input  page_t              commit_pg,
    input  logic               ovw_evt,
    input  logic               miss_evt,
    input  logic               cnt_evt,
    input  logic [TALLY_W-1:0] tally_val,
    output page_t              pg_first,
    output page_t              pg_stop,
    output page_t              pg_bndry,
    output page_t              pg_curr,
    output logic               cfg_save,
    output logic               cfg_mon,
    output logic               rst_flag,
    output logic               cnt_flag
);
    typedef struct packed {
        page_t first;
        page_t stop;
        page_t bndry;
        page_t curr;
        logic  save;
        logic  mon;
        logic  f_ovw;
        logic  f_rst;
        logic  f_miss;
        logic  f_cnt;
    } rf_t;

    rf_t q, d;
    reg_addr_e ra;

    assign ra = reg_addr_e'(reg_addr);

    always_comb begin
        d = q;
        if (reg_we) begin
            case (ra)
                RA_FIRST: d.first = reg_wdata;
                RA_STOP:  d.stop  = reg_wdata;
                RA_BNDRY: begin
                    d.bndry = reg_wdata;
                    if (reg_wdata != q.bndry) d.f_rst = 1'b0;
                end
                RA_CURR:  d.curr  = reg_wdata;
                RA_CFG: begin
                    d.save = reg_wdata[0];
                    d.mon  = reg_wdata[1];
                end
                RA_STAT: begin
                    if (reg_wdata[ST_OVW])  d.f_ovw  = 1'b0;
                    if (reg_wdata[ST_MISS]) d.f_miss = 1'b0;
                    if (reg_wdata[ST_CNT])  d.f_cnt  = 1'b0;
                end
                default: ;
            endcase
        end
        if (commit_vld) d.curr   = commit_pg;
        if (ovw_evt) begin
            d.f_ovw = 1'b1;
            d.f_rst = 1'b1;
        end
        if (miss_evt)   d.f_miss = 1'b1;
        if (cnt_evt)    d.f_cnt  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (ra)
            RA_FIRST: reg_rdata = q.first;
            RA_STOP:  reg_rdata = q.stop;
            RA_BNDRY: reg_rdata = q.bndry;
            RA_CURR:  reg_rdata = q.curr;
            RA_CFG:   reg_rdata = {6'b0, q.mon, q.save};
            RA_STAT:  reg_rdata = {4'b0, q.f_cnt, q.f_miss, q.f_rst, q.f_ovw};
            RA_TALLY: reg_rdata = BYTE_W'(tally_val);
            default:  reg_rdata = '0;
        endcase
    end

    assign pg_first = q.first;
    assign pg_stop  = q.stop;
    assign pg_bndry = q.bndry;
    assign pg_curr  = q.curr;
    assign cfg_save = q.save;
    assign cfg_mon  = q.mon;
    assign rst_flag = q.f_rst;
    assign cnt_flag = q.f_cnt;
endmodule

// File: rtl/rrb_ring_mgr.sv
module rrb_ring_mgr
    import rrb_pkg::*;
#(
    parameter int TALLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_err,
    input  logic              rx_fae_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);
    page_t              pg_first, pg_stop, pg_bndry, pg_curr, commit_pg;
    logic               cfg_save, cfg_mon, commit_vld, ovw_evt, miss_evt;
    logic               cnt_evt, tally_clr, rst_flag, cnt_flag;
    logic [TALLY_W-1:0] tally_val;

    assign tally_clr = reg_we && (reg_addr == RA_TALLY);

    rrb_rx_engine eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start   (rx_start),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_end     (rx_end),
        .rx_crc_err (rx_crc_err),
        .rx_fae_err (rx_fae_err),
        .cfg_save   (cfg_save),
        .cfg_mon    (cfg_mon),
        .pg_first   (pg_first),
        .pg_stop    (pg_stop),
        .pg_bndry   (pg_bndry),
        .pg_curr    (pg_curr),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .commit_vld (commit_vld),
        .commit_pg  (commit_pg),
        .ovw_evt    (ovw_evt),
        .miss_evt   (miss_evt)
    );

    rrb_tally #(.W(TALLY_W)) tally_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (miss_evt),
        .clr     (tally_clr),
        .value   (tally_val),
        .msb_evt (cnt_evt)
    );

    rrb_regs #(.TALLY_W(TALLY_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .commit_vld (commit_vld),
        .commit_pg  (commit_pg),
        .ovw_evt    (ovw_evt),
        .miss_evt   (miss_evt),
        .cnt_evt    (cnt_evt),
        .tally_val  (tally_val),
        .pg_first   (pg_first),
        .pg_stop    (pg_stop),
        .pg_bndry   (pg_bndry),
        .pg_curr    (pg_curr),
        .cfg_save   (cfg_save),
        .cfg_mon    (cfg_mon),
        .rst_flag   (rst_flag),
        .cnt_flag   (cnt_flag)
    );
endmodule

// File: rtl/rrb_ring_mgr_chk.sv
module rrb_ring_mgr_chk
    import rrb_pkg::*;
#(
    parameter int TALLY_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input page_t              pg_first,
    input page_t              pg_stop,
    input logic               commit_vld,
    input page_t              commit_pg,
    input logic               ovw_evt,
    input logic               rst_flag,
    input logic               miss_evt,
    input logic               tally_clr,
    input logic [TALLY_W-1:0] tally_val,
    input logic               cnt_flag
);
    localparam logic [TALLY_W-1:0] BELOW_MSB = {1'b0, {(TALLY_W-1){1'b1}}};

    // R2 / R3: every memory write lands inside the ring
    a_r3_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:OFF_W] >= pg_first && mem_addr[ADDR_W-1:OFF_W] < pg_stop));

    // R5: the committed current page stays within the ring
    a_r5_commit_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> (commit_pg >= pg_first && commit_pg < pg_stop));

    // R8: an overwrite sets the reset flag on the next cycle
    a_r8_ovw_sets_rst: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_evt |=> rst_flag);

    // R11: each missed packet advances the tally by one
    a_r11_tally_step: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_evt && !tally_clr) |=> (tally_val == $past(tally_val) + 1'b1));

    // R11: crossing into the top bit raises the counter flag
    a_r11_msb_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_evt && !tally_clr && tally_val == BELOW_MSB) |=> cnt_flag);
endmodule

bind rrb_ring_mgr rrb_ring_mgr_chk #(.TALLY_W(TALLY_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pg_first   (pg_first),
    .pg_stop    (pg_stop),
    .commit_vld (commit_vld),
    .commit_pg  (commit_pg),
    .ovw_evt    (ovw_evt),
    .rst_flag   (rst_flag),
    .miss_evt   (miss_evt),
    .tally_clr  (tally_clr),
    .tally_val  (tally_val),
    .cnt_flag   (cnt_flag)
);

// File: tb/rrb_ring_mgr_tb_top.sv
module rrb_ring_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_start = 0, rx_valid = 0, rx_end = 0, rx_crc_err = 0, rx_fae_err = 0;
    logic [7:0]  rx_data = 0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // behavioural model state
    int m_first = 0, m_stop = 0, m_bnry = 0, m_curr = 0;
    bit m_save = 0, m_mon = 0;
    bit m_ovw = 0, m_rst = 0, m_miss = 0, m_cnt = 0;
    int m_tally = 0;
    logic [7:0] obs_mem [int];
    logic [7:0] exp_mem [int];
    int exp_addrs[$];
    int obs_writes = 0;

    always #4 clk = ~clk;

    rrb_ring_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_crc_err(rx_crc_err), .rx_fae_err(rx_fae_err),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of every write against the model's ring
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            int pg;
            pg = int'(mem_addr[15:8]);
            obs_mem[int'(mem_addr)] = mem_wdata;
            obs_writes++;
            chk(pg >= m_first && pg < m_stop && pg != m_bnry, "R8 write page", pg, m_bnry);
        end
    end

    function automatic int nxt(int p);
        return ((p + 1) == m_stop) ? m_first : p + 1;
    endfunction

    task automatic wr_reg(int a, int v);
        @(negedge clk);
        reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(v);
        @(negedge clk);
        reg_we = 0;
        case (a)
            0: m_first = v;
            1: m_stop = v;
            2: begin if (v != m_bnry) m_rst = 0; m_bnry = v; end
            3: m_curr = v;
            4: begin m_save = v[0]; m_mon = v[1]; end
            5: begin if (v[0]) m_ovw = 0; if (v[2]) m_miss = 0; if (v[3]) m_cnt = 0; end
            6: m_tally = 0;
            default: ;
        endcase
    endtask

    task automatic rd_reg(int a, output int v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 v = int'(reg_rdata);
    endtask

    task automatic check_state(string tag);
        int v;
        rd_reg(3, v); chk(v == m_curr, {tag, " current page"}, v, m_curr);
        rd_reg(5, v);
        chk(v == (m_cnt * 8 + m_miss * 4 + m_rst * 2 + m_ovw), {tag, " status"}, v,
            m_cnt * 8 + m_miss * 4 + m_rst * 2 + m_ovw);
        rd_reg(6, v); chk(v == m_tally, {tag, " tally"}, v, m_tally);
    endtask

    task automatic send_pkt(int len, bit crc, bit fae, int seed, string tag);
        int pg, off, start, writes, npg;
        bit skip, miss, ovw, bad;
        int base_writes;
        exp_addrs.delete();
        base_writes = obs_writes;
        start = m_curr; pg = m_curr; off = 4; writes = 0;
        skip = 0; miss = 0; ovw = 0;
        if (m_mon) begin skip = 1; miss = 1; end
        else if (m_curr == m_bnry) begin skip = 1; miss = 1; ovw = 1; end
        @(negedge clk); rx_start = 1;
        @(negedge clk); rx_start = 0;
        for (int i = 0; i < len; i++) begin
            int b;
            b = (seed + i * 7) & 255;
            rx_valid = 1; rx_data = 8'(b);
            if (!skip && off == 256) begin
                npg = nxt(pg);
                if (npg == m_bnry) begin skip = 1; miss = 1; ovw = 1; end
                else begin pg = npg; off = 0; end
            end
            if (!skip) begin
                exp_mem[pg * 256 + off] = 8'(b);
                exp_addrs.push_back(pg * 256 + off);
                off++; writes++;
            end
            @(negedge clk);
        end
        rx_valid = 0; rx_end = 1; rx_crc_err = crc; rx_fae_err = fae;
        @(negedge clk);
        rx_end = 0; rx_crc_err = 0; rx_fae_err = 0;
        repeat (8) @(negedge clk);
        bad = crc | fae;
        if (ovw) begin m_ovw = 1; m_rst = 1; end
        if (skip) begin
            if (miss) begin
                m_miss = 1;
                if (m_tally == 127) m_cnt = 1;
                m_tally = (m_tally + 1) & 255;
            end
        end else if (!bad || m_save) begin
            npg = nxt(pg);
            exp_mem[start * 256 + 0] = 8'({fae, crc, !bad});
            exp_mem[start * 256 + 1] = 8'(npg);
            exp_mem[start * 256 + 2] = 8'((len + 4) & 255);
            exp_mem[start * 256 + 3] = 8'((len + 4) >> 8);
            for (int k = 0; k < 4; k++) exp_addrs.push_back(start * 256 + k);
            writes += 4;
            m_curr = npg;
        end
        chk(obs_writes - base_writes == writes, {tag, " write count"}, obs_writes - base_writes, writes);
        foreach (exp_addrs[k]) begin
            int a;
            a = exp_addrs[k];
            if (obs_mem.exists(a)) chk(obs_mem[a] == exp_mem[a], {tag, " mem byte"}, int'(obs_mem[a]), int'(exp_mem[a]));
            else chk(0, {tag, " mem byte missing"}, a, int'(exp_mem[a]));
        end
        check_state(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++; miscompares++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_we == 0, "R1 mem_we idle", int'(mem_we), 0);
        for (int a = 0; a < 7; a++) begin
            rd_reg(a, v); chk(v == 0, "R1 reset register", v, 0);
        end
        rst_n = 1;
        @(negedge clk);
        // R12: map and readback
        wr_reg(0, 8'h10); wr_reg(1, 8'h14); wr_reg(2, 8'h13); wr_reg(3, 8'h10); wr_reg(4, 8'h03);
        rd_reg(0, v); chk(v == 8'h10, "R12 first page", v, 8'h10);
        rd_reg(1, v); chk(v == 8'h14, "R12 stop page", v, 8'h14);
        rd_reg(2, v); chk(v == 8'h13, "R12 boundary", v, 8'h13);
        rd_reg(4, v); chk(v == 8'h03, "R12 config", v, 8'h03);
        wr_reg(4, 0);
        // R2 R4 R5: single-page good packet
        send_pkt(60, 0, 0, 8'h21, "R4 short packet");
        wr_reg(2, 8'h10);
        // R2 R5: packet crossing a page
        send_pkt(300, 0, 0, 8'h33, "R2 page crossing");
        // R3: wrap past last ring page
        wr_reg(2, 8'h12);
        send_pkt(300, 0, 0, 8'h45, "R3 ring wrap");
        // R8: runs into the boundary page
        send_pkt(600, 0, 0, 8'h57, "R8 overwrite");
        // R10: W1C clears ovw and missed, reset flag stays (R9)
        wr_reg(5, 8'h0F);
        check_state("R10 status clear");
        // R9: same boundary value keeps reset flag, new value clears it
        wr_reg(2, 8'h12);
        check_state("R9 same boundary");
        wr_reg(2, 8'h10);
        check_state("R9 new boundary");
        // R6: errored packet dropped without save
        send_pkt(30, 1, 0, 8'h69, "R6 crc discard");
        wr_reg(4, 8'h01);
        send_pkt(20, 0, 1, 8'h7B, "R6 saved errored");
        // R7: monitor mode stores nothing
        wr_reg(4, 8'h02);
        send_pkt(10, 0, 0, 8'h8D, "R7 monitor");
        // R8: start when current equals boundary
        wr_reg(4, 0);
        wr_reg(3, 8'h10);
        send_pkt(5, 0, 0, 8'h9F, "R8 full at start");
        // R11: tally and its top bit
        wr_reg(5, 8'h0F);
        wr_reg(4, 8'h02);
        while (m_tally < 127) send_pkt(1, 0, 0, m_tally, "R11 tally step");
        rd_reg(5, v); chk(v[3] == 0, "R11 flag before msb", v, 0);
        send_pkt(1, 0, 0, 8'h11, "R11 tally msb");
        rd_reg(5, v); chk(v[3] == 1, "R11 flag at msb", v, 8);
        wr_reg(6, 0);
        check_state("R11 tally clear");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule